// File: doc/BRIEF.md
# ALU with condition code register

This block is a 16-bit two's-complement arithmetic and logic unit with a five-bit condition code register. The condition codes sit in the low bits of a 16-bit status word. Each cycle it takes a source operand, a destination operand and an operation code. It drives the operation's result on `res_o` without any register in the path. When the update strobe is high, the condition codes update on the next rising clock edge, following the rules of the selected operation.

The operations are:

- move
- add
- subtract, computed as destination minus source
- bitwise AND
- bitwise NOR
- logical shift left and logical shift right, which shift the destination by a count taken from the source
- clear-flags

Each operation writes only its own subset of the flags. Every other flag keeps its value. Operand fetch, memory access and sequencing belong to the surrounding datapath.

Top module: `alu_ccr`

## Requirements
- R1: Operation code 1 (add) gives `res_o = src_i + dst_i` modulo 2^16. On update it writes all five flags. C (status bit 3) is the carry out of bit 15. O (status bit 4) is the signed overflow of the sum.
- R2: Operation code 2 (subtract) gives `res_o = dst_i - src_i` modulo 2^16. On update it writes all five flags. C is the borrow, which is 1 when src_i > dst_i as unsigned values. O is the signed overflow of the difference.
- R3: Operation codes 3 (AND) and 4 (NOR) give `src_i & dst_i` and `~(src_i | dst_i)`. On update they write only N, Z and P. C and O keep their values.
- R4: Operation code 5 shifts dst_i left by the unsigned count src_i and fills with zeros from the right. A count of 16 or more gives 0. On update it writes only N, Z and P.
- R5: Operation code 6 shifts dst_i right by the unsigned count src_i and fills with zeros from the left. A count of 16 or more gives 0. On update it writes only N, Z and P.
- R6: Operation code 0 (move) gives `res_o = src_i`. It leaves every flag unchanged.
- R7: Operation code 7 (clear-flags) gives `res_o = dst_i`. On update it sets all five flags to 0.
- R8: When an operation writes N, Z and P, they follow the 16-bit result:
  - N (bit 0) is set when the result is negative.
  - Z (bit 1) is set when the result is zero.
  - P (bit 2) is set when the result is positive.
  - At most one of the three is ever set.
- R9: When `upd_i` is low, the status word does not change, whatever the operation.
- R10: Status bits 15 to 5 always read 0. The whole status word is 0 after reset.
- R11: Operation codes 8 to 15 give `res_o = dst_i` and leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 16 | Source operand, which is also the shift count |
| dst_i | input | 16 | Destination operand |
| op_i | input | 4 | Operation code |
| upd_i | input | 1 | Update strobe for the condition codes |
| res_o | output | 16 | Result (combinational) |
| status_o | output | 16 | Status word. Bits 4..0 are O, C, P, Z, N |

## Verification
The assertions assume that `op_i`, `src_i`, `dst_i` and `upd_i` are stable across each rising edge. They also assume that `upd_i` is low while reset is active. The stimulus respects both: it changes the inputs only on falling edges and holds the strobe low during reset. Each strobed update lasts exactly one cycle, so every flag state that is checked follows from a single known operation applied to the state before it.

// File: rtl/alu_ccr_pkg.sv
package alu_ccr_pkg;
  localparam int unsigned FLAG_W = 5;

  localparam int unsigned FLG_N = 0;
  localparam int unsigned FLG_Z = 1;
  localparam int unsigned FLG_P = 2;
  localparam int unsigned FLG_C = 3;
  localparam int unsigned FLG_O = 4;

  typedef enum logic [3:0] {
    OP_MOVE = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_NOR  = 4'd4,
    OP_SHL  = 4'd5,
    OP_SHR  = 4'd6,
    OP_CLR  = 4'd7
  } op_e;

  localparam logic [FLAG_W-1:0] MASK_ALL = 5'b11111;
  localparam logic [FLAG_W-1:0] MASK_NZP = 5'b00111;
  localparam logic [FLAG_W-1:0] MASK_NONE = 5'b00000;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] dst_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cy_o,
  output logic         ovf_o
);
  logic [W-1:0] opnd;
  logic [W:0]   sum;

  // dst - src as dst + ~src + 1
  assign opnd  = sub_i ? ~src_i : src_i;
  assign sum   = {1'b0, dst_i} + {1'b0, opnd} + {{W{1'b0}}, sub_i};
  assign res_o = sum[W-1:0];
  // borrow is the inverse of the carry out in subtract mode
  assign cy_o  = sum[W] ^ sub_i;
  assign ovf_o = (dst_i[W-1] == opnd[W-1]) && (res_o[W-1] != dst_i[W-1]);
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] cnt_i,
  input  logic         right_i,
  output logic [W-1:0] res_o
);
  localparam int unsigned CNT_W = $clog2(W);

  logic         big;
  logic [W-1:0] shl;
  logic [W-1:0] shr;

  assign big = |cnt_i[W-1:CNT_W];
  assign shl = val_i << cnt_i[CNT_W-1:0];
  assign shr = val_i >> cnt_i[CNT_W-1:0];

  always_comb begin
    if (big)          res_o = '0;
    else if (right_i) res_o = shr;
    else              res_o = shl;
  end
endmodule

// File: rtl/alu_ccr_reg.sv
module alu_ccr_reg
  import alu_ccr_pkg::*;
#(
  parameter int unsigned STAT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [FLAG_W-1:0] wmask_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [STAT_W-1:0] status_o
);
  logic [FLAG_W-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (upd_i) begin
      flags_q <= (flags_q & ~wmask_i) | (flags_i & wmask_i);
    end
  end

  assign status_o = {{(STAT_W-FLAG_W){1'b0}}, flags_q};

  // R10
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[STAT_W-1:FLAG_W] == '0);

  // R8
  nzp_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(status_o[FLG_P:FLG_N]));

  for (genvar i = 0; i < FLAG_W; i++) begin : g_keep
    // R3
    flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_i && !wmask_i[i]) |=> $stable(status_o[i]));
  end
endmodule

// File: rtl/alu_ccr.sv
module alu_ccr
  import alu_ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STAT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [3:0]        op_i,
  input  logic              upd_i,
  output logic [DATA_W-1:0] res_o,
  output logic [STAT_W-1:0] status_o
);
  logic [DATA_W-1:0] as_res;
  logic              as_cy;
  logic              as_ovf;
  logic [DATA_W-1:0] sh_res;
  logic [FLAG_W-1:0] wmask;
  logic [FLAG_W-1:0] nxt_flags;
  logic              clr;
  logic              neg;
  logic              zero;

  alu_addsub #(.W(DATA_W)) u_addsub (
    .src_i (src_i),
    .dst_i (dst_i),
    .sub_i (op_i == OP_SUB),
    .res_o (as_res),
    .cy_o  (as_cy),
    .ovf_o (as_ovf)
  );

  alu_shift #(.W(DATA_W)) u_shift (
    .val_i   (dst_i),
    .cnt_i   (src_i),
    .right_i (op_i == OP_SHR),
    .res_o   (sh_res)
  );

  always_comb begin
    res_o = dst_i;
    wmask = MASK_NONE;
    clr   = 1'b0;
    case (op_i)
      OP_MOVE: res_o = src_i;
      OP_ADD, OP_SUB: begin
        res_o = as_res;
        wmask = MASK_ALL;
      end
      OP_AND: begin
        res_o = src_i & dst_i;
        wmask = MASK_NZP;
      end
      OP_NOR: begin
        res_o = ~(src_i | dst_i);
        wmask = MASK_NZP;
      end
      OP_SHL, OP_SHR: begin
        res_o = sh_res;
        wmask = MASK_NZP;
      end
      OP_CLR: begin
        wmask = MASK_ALL;
        clr   = 1'b1;
      end
      default: ;
    endcase
  end

  assign neg  = res_o[DATA_W-1];
  assign zero = (res_o == '0);

  always_comb begin
    nxt_flags        = '0;
    nxt_flags[FLG_N] = neg;
    nxt_flags[FLG_Z] = zero;
    nxt_flags[FLG_P] = !neg && !zero;
    nxt_flags[FLG_C] = as_cy;
    nxt_flags[FLG_O] = as_ovf;
    if (clr) nxt_flags = '0;
  end

  alu_ccr_reg #(.STAT_W(STAT_W)) u_ccr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (upd_i),
    .wmask_i  (wmask),
    .flags_i  (nxt_flags),
    .status_o (status_o)
  );

  // R1
  add_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == OP_ADD) |=>
      status_o[FLG_C] == (({1'b0, $past(src_i)} + {1'b0, $past(dst_i)}) > {1'b0, {DATA_W{1'b1}}}));

  // R2
  sub_borrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == OP_SUB) |=> status_o[FLG_C] == ($past(src_i) > $past(dst_i)));

  // R2
  sub_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SUB) |-> (res_o + src_i) == dst_i);

  // R6
  move_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == OP_MOVE) |=> $stable(status_o));

  // R7
  clr_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == OP_CLR) |=> status_o == '0);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(status_o));
endmodule

// File: tb/alu_ccr_tb.sv
module alu_ccr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic [15:0] dst = '0;
  logic [3:0]  op = '0;
  logic        upd = 1'b0;
  logic [15:0] res;
  logic [15:0] status;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  alu_ccr u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .src_i    (src),
    .dst_i    (dst),
    .op_i     (op),
    .upd_i    (upd),
    .res_o    (res),
    .status_o (status)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [15:0] src;
    logic [15:0] dst;
    logic [15:0] res;
    logic [4:0]  fl;   // O C P Z N
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 16'h0001, 16'h0002, 16'h0003, 5'b00100, 4'd1},  // R1 plain
    '{4'd1, 16'h0001, 16'hFFFF, 16'h0000, 5'b01010, 4'd1},  // R1 carry, zero
    '{4'd1, 16'h0001, 16'h7FFF, 16'h8000, 5'b10001, 4'd1},  // R1 overflow
    '{4'd1, 16'h8000, 16'h8000, 16'h0000, 5'b11010, 4'd1},  // R1 carry+ovf
    '{4'd3, 16'h00F0, 16'h0FF0, 16'h00F0, 5'b11100, 4'd3},  // R3 and keeps C,O
    '{4'd4, 16'h0000, 16'h0000, 16'hFFFF, 5'b11001, 4'd3},  // R3 nor
    '{4'd2, 16'h0003, 16'h0005, 16'h0002, 5'b00100, 4'd2},  // R2 plain
    '{4'd2, 16'h0005, 16'h0003, 16'hFFFE, 5'b01001, 4'd2},  // R2 borrow
    '{4'd2, 16'h0001, 16'h8000, 16'h7FFF, 5'b10100, 4'd2},  // R2 overflow
    '{4'd0, 16'h1234, 16'h0000, 16'h1234, 5'b10100, 4'd6},  // R6 move
    '{4'd5, 16'h0002, 16'h408C, 16'h0230, 5'b10100, 4'd4},  // R4 shl by 2
    '{4'd5, 16'h0010, 16'hFFFF, 16'h0000, 5'b10010, 4'd4},  // R4 count 16
    '{4'd6, 16'h0004, 16'h8000, 16'h0800, 5'b10100, 4'd5},  // R5 shr by 4
    '{4'd6, 16'hFFFF, 16'h1234, 16'h0000, 5'b10010, 4'd5},  // R5 huge count
    '{4'd5, 16'h000F, 16'h0003, 16'h8000, 5'b10001, 4'd4},  // R4 count 15
    '{4'd7, 16'h0001, 16'h5555, 16'h5555, 5'b00000, 4'd7},  // R7 clear
    '{4'd2, 16'h1234, 16'h1234, 16'h0000, 5'b00010, 4'd8},  // R8 zero
    '{4'd4, 16'h00FF, 16'h0F00, 16'hF000, 5'b00001, 4'd8},  // R8 negative
    '{4'd15, 16'h0001, 16'hABCD, 16'hABCD, 5'b00001, 4'd11}, // R11 unused code
    '{4'd6, 16'h0000, 16'h8001, 16'h8001, 5'b00001, 4'd5},  // R5 count 0
    '{4'd1, 16'h8000, 16'hFFFF, 16'h7FFF, 5'b11100, 4'd1}   // R1 neg+neg
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R10 reset status", status, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op  = VEC[i].op;
      src = VEC[i].src;
      dst = VEC[i].dst;
      upd = 1'b1;
      #1 check($sformatf("R%0d vec%0d result", VEC[i].req, i), res, VEC[i].res);
      @(posedge clk);
      #1 check($sformatf("R%0d vec%0d status", VEC[i].req, i), status, {11'b0, VEC[i].fl});
    end

    // R9: strobe low, add that would set C and Z must not touch status 0x001C
    @(negedge clk);
    upd = 1'b0;
    op  = 4'd1;
    src = 16'h0001;
    dst = 16'hFFFF;
    #1 check("R9 result without strobe", res, 16'h0000);
    @(posedge clk);
    #1 check("R9 status held", status, 16'h001C);
    @(negedge clk);
    op = 4'd7;
    @(posedge clk);
    #1 check("R9 clear without strobe", status, 16'h001C);

    // R10: reset mid-run clears status, upper bits zero
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R10 async reset", status, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    // R4 / R5 boundary: count with only a high bit set
    @(negedge clk);
    op  = 4'd5;
    src = 16'h8001;
    dst = 16'h0001;
    upd = 1'b1;
    #1 check("R4 count 0x8001 zero", res, 16'h0000);
    @(posedge clk);
    #1 check("R4 flags after zero shift", status, 16'h0002);
    @(negedge clk);
    upd = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule